// File: doc/BRIEF.md
# Monochrome VGA Raster Controller

This block produces the raster timing and the pixel stream for a two-level display of 576 by 455 pixels, one bit per pixel, whose image sits in a memory shared with another writer. Two counters set the timing: one counts pixel clocks across a line and the other counts lines down a frame. Each counter is a maximal-length linear feedback shift register, not a binary incrementer. Four exact state matches on each counter mark where blanking begins, where sync begins and ends, and where the line or frame ends. The end-of-line or end-of-frame match also reloads the seed. The line counter moves on only at the end of each line.

Image words are pulled in one at a time with a request/acknowledge pair, from linear addresses that begin at a base and rise by one per word. A 16-bit staging register holds the next word while a 16-bit shifter sends out the current one, most significant bit first, one pixel per clock. Each line needs its words loaded exactly on 16-pixel boundaries. The shifter takes a new word at every 16-pixel boundary inside the visible area. The next fetch starts as soon as the staging register has been emptied, so the last word of a line is shown in full before blanking starts. The address returns to the base at the end of the last visible line, ready for the next frame.

The defaults give 800 clocks per line and 525 lines per frame, with sync pulses driven low. Every timing point is a parameter, and the match constants are worked out when the design is elaborated by stepping the LFSR from its seed.

Top module: `mono_raster_ctrl`

## Requirements
- R1: While reset is held, and at the first sample after its release, hsync_n and vsync_n are 1, blank is 1, pixel is 0 and fetch_req is 1. Reset places the timing at pixel 0 of line V_TOTAL-1. The internal reset is released two clock edges after rst_n rises.
- R2: Each line lasts H_TOTAL clocks. hsync_n is 0 exactly at pixel positions H_SYNC_ON to H_SYNC_OFF-1 and is 1 elsewhere.
- R3: Each frame lasts V_TOTAL lines, and the line number changes only at the end of a line. vsync_n is 0 exactly on lines V_SYNC_ON to V_SYNC_OFF-1.
- R4: blank is 1 exactly when the pixel position is at least H_ACTIVE or the line is at least V_ACTIVE.
- R5: pixel is 0 on every clock where blank is 1.
- R6: At a visible position (x, y), pixel equals bit 15-(x mod 16) of the word read from address BASE + y*(H_ACTIVE/16) + x/16. Bit 15 is shown first, and all 16 bits of the last word of a line are shown.
- R7: Acknowledged fetch addresses run BASE, BASE+1, ... up to BASE+FRAME_WORDS-1 and then start again at BASE. FRAME_WORDS is (H_ACTIVE/16)*V_ACTIVE.
- R8: Once fetch_req is raised it stays high, with fetch_addr unchanged, until a clock edge at which fetch_ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | ADDR_W | Word address of the pending fetch |
| fetch_ack | input | 1 | Fetch accepted; fetch_data valid in the same cycle |
| fetch_data | input | WORD_W | Fetched image word |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| pixel | output | 1 | Serial pixel bit |

## Verification
The no-underrun assertion assumes that the arbiter answers a raised fetch_req within twelve clocks. It also assumes that fetch_ack is high for one cycle only, with the data valid in that same cycle. Without these, the shifter would reach a 16-pixel boundary with no staged word. The stimulus meets this assumption by drawing each grant delay from zero to ten waiting cycles. It also holds the delay at ten for a whole frame and at zero for another. The bench raises acknowledge only while a request is visible. It drops acknowledge after one cycle, and it resets in the middle of a frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Feedback tap mask for a maximal-length Fibonacci LFSR of width w
  function automatic logic [15:0] lfsr_taps(input int w);
    case (w)
      8:       return 16'h00B8;
      9:       return 16'h0110;
      11:      return 16'h0500;
      12:      return 16'h0829;
      default: return 16'h0240;
    endcase
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s, input int w);
    logic fb;
    logic [15:0] mask;
    fb   = ^(s & lfsr_taps(w));
    mask = (16'h0001 << w) - 16'h0001;
    return ((s << 1) | {15'b0, fb}) & mask;
  endfunction

  // State reached after n steps from the seed (all zeros except bit 0)
  function automatic logic [15:0] lfsr_at(input int w, input int n);
    logic [15:0] s;
    s = 16'h0001;
    for (int i = 0; i < n; i++) s = lfsr_next(s, w);
    return s;
  endfunction

endpackage

// File: rtl/raster_lfsr_timer.sv
module raster_lfsr_timer
  import raster_pkg::*;
#(
  parameter int W          = 10,
  parameter int P_BLANK    = 576,
  parameter int P_SYNC_ON  = 600,
  parameter int P_SYNC_OFF = 696,
  parameter int P_TOTAL    = 800,
  parameter int P_RESET    = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic wrap,
  output logic blank_evt,
  output logic blank_q,
  output logic blank_d,
  output logic sync_n_q
);

  // Each event is decoded one count early so the flag flips on the position itself
  localparam logic [W-1:0] K_SEED     = W'(lfsr_at(W, 0));
  localparam logic [W-1:0] K_BLANK    = W'(lfsr_at(W, P_BLANK - 1));
  localparam logic [W-1:0] K_SYNC_ON  = W'(lfsr_at(W, P_SYNC_ON - 1));
  localparam logic [W-1:0] K_SYNC_OFF = W'(lfsr_at(W, P_SYNC_OFF - 1));
  localparam logic [W-1:0] K_END      = W'(lfsr_at(W, P_TOTAL - 1));
  localparam logic [W-1:0] K_RESET    = W'(lfsr_at(W, P_RESET));
  localparam logic RST_BLANK  = (P_RESET >= P_BLANK);
  localparam logic RST_SYNC_N = !((P_RESET >= P_SYNC_ON) && (P_RESET < P_SYNC_OFF));

  logic [W-1:0] state_q, state_d;
  logic         sync_n_d;
  logic         hit_blank, hit_sync_on, hit_sync_off, hit_end;

  assign hit_blank    = (state_q == K_BLANK);
  assign hit_sync_on  = (state_q == K_SYNC_ON);
  assign hit_sync_off = (state_q == K_SYNC_OFF);
  assign hit_end      = (state_q == K_END);

  assign wrap      = step & hit_end;
  assign blank_evt = step & hit_blank;

  always_comb begin
    state_d  = state_q;
    blank_d  = blank_q;
    sync_n_d = sync_n_q;
    if (step) begin
      state_d = hit_end ? K_SEED : W'(lfsr_next(16'(state_q), W));
      if (hit_blank)      blank_d = 1'b1;
      else if (hit_end)   blank_d = 1'b0;
      if (hit_sync_on)       sync_n_d = 1'b0;
      else if (hit_sync_off) sync_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= K_RESET;
      blank_q  <= RST_BLANK;
      sync_n_q <= RST_SYNC_N;
    end else if (step) begin
      state_q  <= state_d;
      blank_q  <= blank_d;
      sync_n_q <= sync_n_d;
    end
  end

  // R2 for the line instance, R3 for the frame instance
  assert_sync_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_n_q) |-> $past(step && (hit_sync_on || hit_sync_off)));

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (state_q == K_SEED));

  assert_blank_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_q) |-> $past(step && hit_blank));

endmodule

// File: rtl/raster_fetch.sv
module raster_fetch #(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 15,
  parameter int FRAME_WORDS = 16380,
  parameter int BASE        = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic              ack,
  input  logic [WORD_W-1:0] rdata,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] stage_word,
  output logic              stage_full
);

  localparam int CNT_W = $clog2(FRAME_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_WORDS);

  logic [CNT_W-1:0]  count_q, count_d;
  logic              full_d;
  logic              grant;

  assign req   = !stage_full && (count_q != LAST_CNT);
  assign grant = req & ack;
  assign addr  = ADDR_W'(BASE) + ADDR_W'(count_q);

  always_comb begin
    count_d = count_q;
    full_d  = stage_full;
    if (restart)    count_d = '0;
    else if (grant) count_d = count_q + 1'b1;
    if (grant)      full_d = 1'b1;
    else if (take)  full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      stage_full <= 1'b0;
    end else begin
      count_q    <= count_d;
      stage_full <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage_word <= '0;
    else if (grant) stage_word <= rdata;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr)));

  assert_restart_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> ((count_q == LAST_CNT) && !stage_full));

  assert_no_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> stage_full);

endmodule

// File: rtl/raster_shifter.sv
module raster_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              last,
  output logic              msb
);

  localparam int PH_W = $clog2(WORD_W);
  localparam logic [PH_W-1:0] PH_END = PH_W'(WORD_W - 1);

  logic [PH_W-1:0]   phase_q;
  logic [WORD_W-1:0] sh_q, sh_d;

  assign last = (phase_q == PH_END);
  assign msb  = sh_q[WORD_W-1];

  always_comb begin
    if (last) sh_d = load ? word : '0;
    else      sh_d = {sh_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sh_q    <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
      sh_q    <= sh_d;
    end
  end

  assert_load_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> last);

endmodule

// File: rtl/mono_raster_ctrl.sv
module mono_raster_ctrl #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 15,
  parameter int LFSR_W     = 10,
  parameter int H_ACTIVE   = 576,
  parameter int H_SYNC_ON  = 600,
  parameter int H_SYNC_OFF = 696,
  parameter int H_TOTAL    = 800,
  parameter int V_ACTIVE   = 455,
  parameter int V_SYNC_ON  = 480,
  parameter int V_SYNC_OFF = 482,
  parameter int V_TOTAL    = 525,
  parameter int BASE       = 0
) (
  input  logic              clk_pix,
  input  logic              rst_n,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [WORD_W-1:0] fetch_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic              pixel
);

  localparam int WORDS_PER_LINE = H_ACTIVE / WORD_W;
  localparam int FRAME_WORDS    = WORDS_PER_LINE * V_ACTIVE;

  // R1: asynchronous assertion, release after two clock edges
  logic rst_meta, rst_sync;
  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic h_wrap, h_blank_evt, hblank_q, hblank_d, h_sync_n;
  logic v_wrap, v_blank_evt, vblank_q, vblank_d, v_sync_n;
  logic take, ph_last, shift_msb;
  logic [WORD_W-1:0] stage_word;
  logic stage_full;

  raster_lfsr_timer #(
    .W(LFSR_W), .P_BLANK(H_ACTIVE), .P_SYNC_ON(H_SYNC_ON),
    .P_SYNC_OFF(H_SYNC_OFF), .P_TOTAL(H_TOTAL), .P_RESET(0)
  ) u_line_timer (
    .clk(clk_pix), .rst_n(rst_sync), .step(1'b1),
    .wrap(h_wrap), .blank_evt(h_blank_evt), .blank_q(hblank_q),
    .blank_d(hblank_d), .sync_n_q(h_sync_n)
  );

  raster_lfsr_timer #(
    .W(LFSR_W), .P_BLANK(V_ACTIVE), .P_SYNC_ON(V_SYNC_ON),
    .P_SYNC_OFF(V_SYNC_OFF), .P_TOTAL(V_TOTAL), .P_RESET(V_TOTAL - 1)
  ) u_frame_timer (
    .clk(clk_pix), .rst_n(rst_sync), .step(h_wrap),
    .wrap(v_wrap), .blank_evt(v_blank_evt), .blank_q(vblank_q),
    .blank_d(vblank_d), .sync_n_q(v_sync_n)
  );

  // Load at a word boundary only if the next position is visible
  assign take = ph_last & ~hblank_d & ~vblank_d;

  raster_fetch #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS), .BASE(BASE)
  ) u_fetch (
    .clk(clk_pix), .rst_n(rst_sync), .restart(v_blank_evt), .take(take),
    .ack(fetch_ack), .rdata(fetch_data), .req(fetch_req), .addr(fetch_addr),
    .stage_word(stage_word), .stage_full(stage_full)
  );

  raster_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk(clk_pix), .rst_n(rst_sync), .load(take), .word(stage_word),
    .last(ph_last), .msb(shift_msb)
  );

  assign hsync_n = h_sync_n;
  assign vsync_n = v_sync_n;
  assign blank   = hblank_q | vblank_q;
  assign pixel   = shift_msb & ~blank;

  assert_frame_wrap_R3: assert property (@(posedge clk_pix) disable iff (!rst_sync)
    v_wrap |=> !vblank_q);

  assert_line_blank_R4: assert property (@(posedge clk_pix) disable iff (!rst_sync)
    h_blank_evt |=> hblank_q);

  assert_vline_hold_R3: assert property (@(posedge clk_pix) disable iff (!rst_sync)
    !h_wrap |=> $stable(vblank_q) && $stable(v_sync_n));

endmodule

// File: tb/test_mono_raster_ctrl.sv
module test_mono_raster_ctrl;
  localparam int WW = 16, AW = 15;
  localparam int HA = 64, HS0 = 72, HS1 = 84, HT = 96;
  localparam int VA = 6, VS0 = 7, VS1 = 8, VT = 10;
  localparam int BASE = 256;
  localparam int WPL = HA / WW, FW = WPL * VA;

  logic clk = 1'b0;
  logic rst_n, req, ack, hs, vs, bl, px;
  logic [AW-1:0] addr;
  logic [WW-1:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit live = 1'b0;
  int lat_mode = 0;
  int exp_idx = 0;
  int hp, vp;
  bit p_req, p_ack;
  logic [AW-1:0] p_addr;

  always #4 clk = ~clk;

  mono_raster_ctrl #(
    .WORD_W(WW), .ADDR_W(AW), .LFSR_W(10),
    .H_ACTIVE(HA), .H_SYNC_ON(HS0), .H_SYNC_OFF(HS1), .H_TOTAL(HT),
    .V_ACTIVE(VA), .V_SYNC_ON(VS0), .V_SYNC_OFF(VS1), .V_TOTAL(VT),
    .BASE(BASE)
  ) i_mono_raster_ctrl (
    .clk_pix(clk), .rst_n(rst_n), .fetch_req(req), .fetch_addr(addr),
    .fetch_ack(ack), .fetch_data(rdata), .hsync_n(hs), .vsync_n(vs),
    .blank(bl), .pixel(px)
  );

  function automatic logic [15:0] mem_word(input int a);
    logic [31:0] x;
    x = a * 32'h9E3779B1;
    return x[23:8] ^ 16'(a);
  endfunction

  function automatic int pick_wait();
    if (lat_mode == 1) return 10;
    if (lat_mode == 2) return 0;
    return int'($urandom_range(10, 0));
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at h=%0d v=%0d: actual %0h expected %0h", rq, hp, vp, act, exp);
    end
  endtask

  // Memory arbiter model: grants after a chosen number of waiting cycles
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    ack = 1'b0;
    rdata = '0;
    forever begin
      @(negedge clk);
      if (!live) begin
        ack = 1'b0;
        wait_cnt = 0;
      end else if (ack) begin
        ack = 1'b0;
      end else if (req) begin
        if (wait_cnt <= 0) begin
          chk(int'(addr) == BASE + exp_idx, "R7 fetch order", int'(addr), BASE + exp_idx);
          rdata = mem_word(int'(addr));
          ack = 1'b1;
          exp_idx = (exp_idx + 1) % FW;
          wait_cnt = pick_wait();
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic do_reset();
    live = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(hs == 1'b1, "R1 hsync_n in reset", hs, 1);
      chk(vs == 1'b1, "R1 vsync_n in reset", vs, 1);
      chk(bl == 1'b1, "R1 blank in reset", bl, 1);
      chk(px == 1'b0, "R1 pixel in reset", px, 0);
      chk(req == 1'b1, "R1 fetch_req in reset", req, 1);
    end
    exp_idx = 0;
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    live = 1'b1;
    hp = 0;
    vp = VT - 1;
    p_req = 1'b0;
    p_ack = 1'b0;
    p_addr = '0;
  endtask

  task automatic run_cycles(input int n);
    repeat (n) begin
      bit exp_bl;
      logic [15:0] w;
      @(negedge clk);
      #1;
      chk(hs == !((hp >= HS0) && (hp < HS1)), "R2 hsync_n", hs, !((hp >= HS0) && (hp < HS1)));
      chk(vs == !((vp >= VS0) && (vp < VS1)), "R3 vsync_n", vs, !((vp >= VS0) && (vp < VS1)));
      exp_bl = (hp >= HA) || (vp >= VA);
      chk(bl == exp_bl, "R4 blank", bl, exp_bl);
      if (exp_bl) begin
        chk(px == 1'b0, "R5 pixel dark in blank", px, 0);
      end else begin
        w = mem_word(BASE + vp * WPL + hp / WW);
        chk(px == w[WW - 1 - (hp % WW)], "R6 pixel value", px, w[WW - 1 - (hp % WW)]);
      end
      if (p_req && !p_ack) begin
        chk(req == 1'b1, "R8 request held", req, 1);
        chk(addr == p_addr, "R8 address stable", int'(addr), int'(p_addr));
      end
      p_req = req;
      p_ack = ack;
      p_addr = addr;
      hp++;
      if (hp == HT) begin
        hp = 0;
        vp = (vp + 1) % VT;
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b1;
    do_reset();
    lat_mode = 0;
    run_cycles(HT * VT * 2);
    lat_mode = 1;                 // slowest allowed grants for a full frame
    run_cycles(HT * VT);
    lat_mode = 0;
    run_cycles(HT * VT / 2 + 37);
    do_reset();                   // R1 again after a reset in mid-frame
    lat_mode = 2;                 // immediate grants
    run_cycles(HT * VT);
    lat_mode = 0;
    run_cycles(HT * VT * 2);
    summary();
    $finish;
  end

endmodule